// File: doc/BRIEF.md
# Port Link and Activity Indicator

This block generates two status indicators for one port. The indicators are meant for LEDs or debug pins that a slow serial output expander drives. Both indicators are active-low. The link indicator shows whether the data link layer is up, and it is decoded from the current link training state code. The activity indicator shows recent transaction-layer traffic in either direction. It is a pulse stretcher, so a single packet stays visible for long enough to be seen.

The expander may refresh its outputs no more often than once every 40 ms. The block counts a free-running millisecond tick and raises a one-cycle update strobe every 40 ticks. Both indicators are registered only on that strobe. The activity hold is counted in whole update periods, which gives a visible activity pulse of at least 200 ms. Packets flagged as vendor-defined messages never light the activity indicator.

Top module: `port_status_ind`

## Requirements
- R1: The link state encoding is 4 bits: Detect=0, Polling=1, Configuration=2, L0=3, L0s=4, L1=5, L2=6, Recovery=7, HotReset=8, Disabled=9, Loopback=10, and codes 11 to 15 are unused. After an update strobe, `linkup_n` is 0 if the state sampled with that strobe was 3, 4, 5 or 7. For every other code it is 1.
- R2: `linkup_n` and `active_n` change only on the clock edge at which `upd_stb` is 1. In every other cycle they keep their value.
- R3: `upd_stb` is a single-cycle pulse. It is 1 in the cycle after the clock edge that counts the 40th `ms_tick` since reset or since the previous strobe, and it is 0 otherwise.
- R4: A qualifying activity event is `tx_tlp`=1 with `tx_vdm`=0, or `rx_tlp`=1 with `rx_vdm`=0. A strobe with its vendor flag set is ignored, so vendor-only traffic leaves `active_n` at 1.
- R5: Suppose a qualifying event occurs outside a strobe cycle, with no event after it. Then `active_n` becomes 0 after the first following update strobe. It remains 0 after strobes two to five, and it returns to 1 after the sixth. If the event coincides with a strobe, `active_n` becomes 0 on that strobe and returns to 1 after the sixth strobe that follows.
- R6: Each qualifying event reloads the hold counter to five update periods, so a new event during the hold extends it in full. A reload takes priority over the decrement on a strobe.
- R7: Transmit and receive events in the same cycle count as one event. Their effect equals that of a single event.
- R8: While `rst_n` is 0, `linkup_n` and `active_n` are 1, `upd_stb` is 0, and the hold and tick counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ltssm_state | input | 4 | Current link training state code |
| tx_tlp | input | 1 | A packet was transmitted this cycle |
| tx_vdm | input | 1 | The transmitted packet is a vendor-defined message |
| rx_tlp | input | 1 | A packet was received this cycle |
| rx_vdm | input | 1 | The received packet is a vendor-defined message |
| linkup_n | output | 1 | Link-up indicator, active-low |
| active_n | output | 1 | Activity indicator, active-low |
| upd_stb | output | 1 | Expander update strobe, once per 40 ms |

## Verification
`upd_stb` rises one cycle after the edge that counts the 40th tick. The two indicators change one cycle after that, on the edge at which the strobe is high. Neither indicator can move between strobes.

A bench reference model advances at each rising edge. The bench drives inputs only on falling edges and compares all three outputs on the falling edge after every rising edge, so each sample sees exactly one register stage of change.

The directed hold scenarios count strobes and sample on the falling edge after each strobe cycle. By then the indicator registered on that strobe is settled. Events are injected right after a strobe has been observed, so they never coincide with one.

// File: rtl/psi_pkg.sv
package psi_pkg;

  localparam int unsigned STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_DETECT    = 4'd0,
    ST_POLLING   = 4'd1,
    ST_CONFIG    = 4'd2,
    ST_L0        = 4'd3,
    ST_L0S       = 4'd4,
    ST_L1        = 4'd5,
    ST_L2        = 4'd6,
    ST_RECOVERY  = 4'd7,
    ST_HOT_RESET = 4'd8,
    ST_DISABLED  = 4'd9,
    ST_LOOPBACK  = 4'd10
  } link_state_e;

  // Data link layer is considered up in the active and low-power link states.
  function automatic logic link_is_up(logic [STATE_W-1:0] code);
    logic up;
    case (code)
      ST_L0, ST_L0S, ST_L1, ST_RECOVERY: up = 1'b1;
      default:                           up = 1'b0;
    endcase
    return up;
  endfunction

endpackage

// File: rtl/psi_upd_timer.sv
module psi_upd_timer #(
  parameter int unsigned UPD_MS = 40,
  localparam int unsigned CNT_W = (UPD_MS > 1) ? $clog2(UPD_MS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  output logic upd_stb
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_MS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;
  logic             wrap;

  assign wrap = ms_tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (ms_tick) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
    stb_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign upd_stb = stb_q;

endmodule

// File: rtl/psi_act_hold.sv
module psi_act_hold #(
  parameter int unsigned HOLD_PERIODS = 5,
  localparam int unsigned HOLD_W = $clog2(HOLD_PERIODS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_tlp,
  input  logic              tx_vdm,
  input  logic              rx_tlp,
  input  logic              rx_vdm,
  input  logic              upd_stb,
  output logic              act_pending,
  output logic [HOLD_W-1:0] hold_cnt
);

  localparam logic [HOLD_W-1:0] RELOAD = HOLD_W'(HOLD_PERIODS);

  logic              evt;
  logic [HOLD_W-1:0] hold_q, hold_d;

  // Both directions merge into one event; vendor messages are filtered.
  assign evt = (tx_tlp && !tx_vdm) || (rx_tlp && !rx_vdm);

  always_comb begin
    hold_d = hold_q;
    if (evt) begin
      hold_d = RELOAD;
    end else if (upd_stb && (hold_q != '0)) begin
      hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign act_pending = evt || (hold_q != '0);
  assign hold_cnt    = hold_q;

endmodule

// File: rtl/psi_out_reg.sv
module psi_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_stb,
  input  logic link_up,
  input  logic act_pending,
  output logic linkup_n,
  output logic active_n
);

  logic link_n_q, link_n_d;
  logic act_n_q, act_n_d;

  always_comb begin
    link_n_d = link_n_q;
    act_n_d  = act_n_q;
    if (upd_stb) begin
      link_n_d = !link_up;
      act_n_d  = !act_pending;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_n_q <= 1'b1;
      act_n_q  <= 1'b1;
    end else begin
      link_n_q <= link_n_d;
      act_n_q  <= act_n_d;
    end
  end

  assign linkup_n = link_n_q;
  assign active_n = act_n_q;

endmodule

// File: rtl/port_status_ind.sv
module port_status_ind #(
  parameter int unsigned UPD_MS       = 40,
  parameter int unsigned HOLD_PERIODS = 5,
  localparam int unsigned HOLD_W      = $clog2(HOLD_PERIODS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ms_tick,
  input  logic [psi_pkg::STATE_W-1:0] ltssm_state,
  input  logic                        tx_tlp,
  input  logic                        tx_vdm,
  input  logic                        rx_tlp,
  input  logic                        rx_vdm,
  output logic                        linkup_n,
  output logic                        active_n,
  output logic                        upd_stb
);

  logic              stb;
  logic              pending;
  logic              link_up;
  logic [HOLD_W-1:0] hold_cnt;

  assign link_up = psi_pkg::link_is_up(ltssm_state);

  psi_upd_timer #(.UPD_MS(UPD_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .upd_stb (stb)
  );

  psi_act_hold #(.HOLD_PERIODS(HOLD_PERIODS)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_tlp      (tx_tlp),
    .tx_vdm      (tx_vdm),
    .rx_tlp      (rx_tlp),
    .rx_vdm      (rx_vdm),
    .upd_stb     (stb),
    .act_pending (pending),
    .hold_cnt    (hold_cnt)
  );

  psi_out_reg u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_stb     (stb),
    .link_up     (link_up),
    .act_pending (pending),
    .linkup_n    (linkup_n),
    .active_n    (active_n)
  );

  assign upd_stb = stb;

endmodule

// File: rtl/psi_chk.sv
module psi_chk #(
  parameter int unsigned HOLD_PERIODS = 5,
  parameter int unsigned HOLD_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        ltssm_state,
  input logic              tx_tlp,
  input logic              tx_vdm,
  input logic              rx_tlp,
  input logic              rx_vdm,
  input logic              linkup_n,
  input logic              active_n,
  input logic              upd_stb,
  input logic [HOLD_W-1:0] hold_cnt
);

  logic evt;
  logic want_up;
  assign evt     = (tx_tlp && !tx_vdm) || (rx_tlp && !rx_vdm);
  assign want_up = (ltssm_state == 4'd3) || (ltssm_state == 4'd4) ||
                   (ltssm_state == 4'd5) || (ltssm_state == 4'd7);

  // R1: link indicator follows the state sampled with the strobe
  p_link_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> (linkup_n == !$past(want_up)));

  // R2: indicators hold between strobes
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> ($stable(linkup_n) && $stable(active_n)));

  // R3: strobe is a single-cycle pulse
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R5: event coincident with a strobe lights the indicator at once
  p_act_light_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && evt) |=> !active_n);

  // R6: a qualifying event reloads the full hold
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (hold_cnt == HOLD_W'(HOLD_PERIODS)));

  // R4: vendor-only or no traffic never raises the hold counter
  p_vdm_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> (hold_cnt <= $past(hold_cnt)));

endmodule

bind port_status_ind psi_chk #(
  .HOLD_PERIODS (HOLD_PERIODS),
  .HOLD_W       (HOLD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ltssm_state (ltssm_state),
  .tx_tlp      (tx_tlp),
  .tx_vdm      (tx_vdm),
  .rx_tlp      (rx_tlp),
  .rx_vdm      (rx_vdm),
  .linkup_n    (linkup_n),
  .active_n    (active_n),
  .upd_stb     (upd_stb),
  .hold_cnt    (hold_cnt)
);

// File: tb/port_status_ind_tb.sv
`timescale 1ns/1ps
module port_status_ind_tb;

  localparam int UPD   = 40;
  localparam int HOLD  = 5;
  localparam int WDOG  = 150000;

  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic [3:0] st;
  logic       tx_tlp, tx_vdm, rx_tlp, rx_vdm;
  logic       linkup_n, active_n, upd_stb;

  int n_chk;
  int n_bad;
  int cyc;
  bit cmp_on;
  bit done;

  // reference model state
  int  m_cnt, m_hold;
  bit  m_upd, m_link_n, m_act_n;

  port_status_ind u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .ltssm_state (st),
    .tx_tlp      (tx_tlp),
    .tx_vdm      (tx_vdm),
    .rx_tlp      (rx_tlp),
    .rx_vdm      (rx_vdm),
    .linkup_n    (linkup_n),
    .active_n    (active_n),
    .upd_stb     (upd_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit exp_up(logic [3:0] s);
    return (s == 4'd3) || (s == 4'd4) || (s == 4'd5) || (s == 4'd7);
  endfunction

  function automatic bit exp_evt(logic t, logic tv, logic r, logic rv);
    return (t && !tv) || (r && !rv);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_upd = 0; m_link_n = 1; m_act_n = 1;
    end else begin
      bit e, nu;
      int nh;
      e  = exp_evt(tx_tlp, tx_vdm, rx_tlp, rx_vdm);
      nu = ms_tick && (m_cnt == UPD - 1);
      if (ms_tick) m_cnt = (m_cnt == UPD - 1) ? 0 : m_cnt + 1;
      if (m_upd) begin
        m_act_n  = !(e || (m_hold != 0));
        m_link_n = !exp_up(st);
      end
      nh = m_hold;
      if (e) nh = HOLD;
      else if (m_upd && m_hold != 0) nh = m_hold - 1;
      m_hold = nh;
      m_upd  = nu;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R1/R2 linkup_n model", linkup_n, m_link_n);
      chk("R5 active_n model", active_n, m_act_n);
      chk("R3 upd_stb model", upd_stb, m_upd);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle_inputs();
    tx_tlp = 0; tx_vdm = 0; rx_tlp = 0; rx_vdm = 0;
  endtask

  // wait until a strobe has been seen; returns on the negedge after it,
  // when the indicators registered on that strobe are visible
  task automatic wait_strobe();
    do @(negedge clk); while (!upd_stb);
    @(negedge clk);
  endtask

  task automatic pulse(bit t, bit tv, bit r, bit rv);
    tx_tlp = t; tx_vdm = tv; rx_tlp = r; rx_vdm = rv;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; cmp_on = 0; done = 0;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; ms_tick = 0; st = 4'd0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 linkup_n in reset", linkup_n, 1);
    chk("R8 active_n in reset", active_n, 1);
    chk("R8 upd_stb in reset", upd_stb, 0);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    ms_tick = 1;

    // R3: strobe arrives exactly one cycle after the 40th tick edge
    begin
      int k;
      k = 0;
      while (!upd_stb) begin @(negedge clk); k++; end
      chk("R3 first strobe cycle", k, UPD);
      @(negedge clk);
      chk("R3 strobe width", upd_stb, 0);
    end

    // R1: each state code decoded
    for (int s = 0; s < 16; s++) begin
      st = 4'(s);
      wait_strobe();
      chk("R1 decode", linkup_n, exp_up(4'(s)) ? 0 : 1);
    end
    st = 4'd3;

    // R4: vendor-only traffic ignored
    wait_strobe();
    for (int i = 0; i < 20; i++) pulse(i[0], 1, !i[0], 1);
    pulse(1, 1, 1, 1);
    for (int i = 0; i < 7; i++) begin
      wait_strobe();
      chk("R4 vdm ignored", active_n, 1);
    end

    // R5 and R7: simultaneous tx/rx event, hold of five updates
    pulse(1, 0, 1, 0);
    for (int i = 1; i <= 6; i++) begin
      wait_strobe();
      chk(i < 6 ? "R7/R5 held" : "R7/R5 release", active_n, i < 6 ? 0 : 1);
    end

    // R5: single rx event with tx vendor flag on same cycle
    pulse(1, 1, 1, 0);
    for (int i = 1; i <= 6; i++) begin
      wait_strobe();
      chk(i < 6 ? "R5 rx held" : "R5 rx release", active_n, i < 6 ? 0 : 1);
    end

    // R6: retrigger during the hold reloads the full count
    pulse(1, 0, 0, 0);
    repeat (3) wait_strobe();
    pulse(0, 0, 1, 0);
    for (int i = 1; i <= 6; i++) begin
      wait_strobe();
      chk(i < 6 ? "R6 extended" : "R6 release", active_n, i < 6 ? 0 : 1);
    end

    // R2: indicators do not move between strobes
    pulse(1, 0, 0, 0);
    st = 4'd0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!upd_stb) chk("R2 stable link", linkup_n, 0);
    end

    // constrained random phase, checked by the model every cycle
    for (int i = 0; i < 30000; i++) begin
      ms_tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) == 0) st = 4'($urandom_range(0, 15));
      tx_tlp = ($urandom_range(0, 399) == 0);
      tx_vdm = ($urandom_range(0, 2) == 0);
      rx_tlp = ($urandom_range(0, 399) == 0);
      rx_vdm = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    idle_inputs();

    // R8: asynchronous reset mid-run clears everything
    ms_tick = 1;
    pulse(1, 0, 0, 0);
    wait_strobe();
    cmp_on = 0;
    #3 rst_n = 0;
    #2;
    chk("R8 active_n async reset", active_n, 1);
    chk("R8 linkup_n async reset", linkup_n, 1);
    chk("R8 upd_stb async reset", upd_stb, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    repeat (200) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule